// File: doc/BRIEF.md
# Tracking-Error Slope Corrector

This block watches the tracking error (reference trajectory minus measured phase error) at the start of each lock interval. It turns the slope of that error into a signed correction, in clock ticks, for the interval between trajectory steps. Each accepted error sample goes into a circular history. The block takes the rate as the newest sample minus the sample stored `LAG` samples before it. Over an observation window of the first `WIN` samples of the run, it records the most positive and the most negative rate seen.

When the window closes, the block keeps whichever of the two peaks has the larger magnitude. It applies a minimum-magnitude threshold only when the positive peak is the one kept. It then multiplies that peak by a signed gain and scales the product down. The result is clamped to a symmetric limit and held on the output until the next run starts. A one-cycle strobe marks the cycle in which the new value appears. With the defaults (one sample every 1.6 us, 80 MHz clock), the lag is 112 samples, the window is 225 samples (360 us), and the limit is ±24 ticks (±0.3 us).

Top module: `err_slope_corrector`

## Requirements
- R1: After reset, `intervalOffset` is 0 and `offsetValid` is 0.
- R2: While fewer than `LAG` samples of the current run are stored, the rate counts as 0. A constant error therefore yields an offset of 0, whatever its level.
- R3: Once `LAG` samples are stored, the rate for sample k is x[k] − x[k−LAG]. For an error ramp of slope s per sample, that is s·LAG.
- R4: Only the first `WIN` accepted samples after `runStart` affect the result. Later samples change neither output, and the offset is held until the next `runStart`.
- R5: The positive peak is kept only if it is strictly larger than the magnitude of the negative peak. Otherwise the negative peak is kept. The kept peak's sign sets the offset's sign.
- R6: `gainCode` is 14-bit offset binary with 0x2000 as zero, so the signed gain is `gainCode` − 8192. The offset is floor(gain·peak / 2^`GAIN_SHIFT`), and `GAIN_SHIFT` defaults to 10.
- R7: If the positive peak is kept and is less than `posThresh`, the offset is 0. A kept negative peak is never compared with the threshold.
- R8: The offset is clamped to the range −`OFS_LIMIT` to +`OFS_LIMIT`.
- R9: `offsetValid` is high for exactly one cycle. That cycle is the second rising edge after the edge that accepts the window's last sample, and the new `intervalOffset` appears on that same edge.
- R10: `runStart` clears the offset to 0 and the strobe to 0 on the next edge. It also empties the history and discards any peaks, and it restarts the window even in the middle of a run. A sample offered in the same cycle as `runStart` is not accepted.
- R11: A cycle with `sampleValid` low neither stores a sample nor advances the window. Samples offered before the first `runStart` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runStart | input | 1 | One-cycle pulse that begins a lock interval |
| sampleValid | input | 1 | A new error sample is present on `sampleErr` |
| sampleErr | input | ERR_W | Tracking error sample, two's complement |
| gainCode | input | GAIN_W | Rate gain, offset binary (0x2000 is zero) |
| posThresh | input | ERR_W | Minimum magnitude that a kept positive peak must reach, unsigned |
| intervalOffset | output | OFS_W | Signed step-interval correction in clock ticks, held |
| offsetValid | output | 1 | One-cycle strobe when `intervalOffset` is updated |

## Verification
The hardest case to reach is a window that contains both positive and negative rates of different sizes. Only then does the peak choice, and the rule that the threshold applies to one side only, actually decide the result. The bench drives piecewise-linear error sequences: a rising leg followed by a falling one that crosses over after the history has filled. This puts a moderate positive peak and a larger or smaller negative peak in the same window. A second hard case is a restart part-way through a window, after a large peak has already been captured. The bench pulses `runStart` after 200 steep samples and checks that the following run's result shows no trace of them.

// File: rtl/slope_corr_pkg.sv
package slope_corr_pkg;

  // Strobes passed from the window control to the datapath
  typedef struct packed {
    logic clear;   // start of run: empty history, drop peaks, zero output
    logic take;    // accept the sample on the input this cycle
    logic finish;  // window closed last cycle: load result
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_OBSERVE = 2'd1,
    ST_HOLD    = 2'd2
  } winState_t;

endpackage

// File: rtl/slope_corr_ctrl.sv
module slope_corr_ctrl
  import slope_corr_pkg::*;
#(
  parameter int WIN = 225
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runStart,
  input  logic        sampleValid,
  output ctlStrobes_t ctl
);

  localparam int CNT_W = $clog2(WIN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN - 1);

  winState_t        state;
  logic [CNT_W-1:0] sampleCnt;
  logic             finishQ;

  always_comb begin
    ctl.clear  = runStart;
    ctl.take   = sampleValid && !runStart && (state == ST_OBSERVE);
    ctl.finish = finishQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sampleCnt <= '0;
      finishQ   <= 1'b0;
    end else if (runStart) begin
      state     <= ST_OBSERVE;
      sampleCnt <= '0;
      finishQ   <= 1'b0;
    end else begin
      finishQ <= 1'b0;
      if (ctl.take) begin
        if (sampleCnt == LAST_IDX) begin
          state   <= ST_HOLD;
          finishQ <= 1'b1;
        end else begin
          sampleCnt <= sampleCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/slope_corr_dp.sv
module slope_corr_dp
  import slope_corr_pkg::*;
#(
  parameter int ERR_W      = 12,
  parameter int LAG        = 112,
  parameter int GAIN_W     = 14,
  parameter int GAIN_SHIFT = 10,
  parameter int OFS_LIMIT  = 24,
  parameter int OFS_W      = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              ctl,
  input  logic signed [ERR_W-1:0]  sampleErr,
  input  logic [GAIN_W-1:0]        gainCode,
  input  logic [ERR_W-1:0]         posThresh,
  output logic signed [OFS_W-1:0]  intervalOffset,
  output logic                     offsetValid
);

  localparam int RATE_W = ERR_W + 1;
  localparam int MAG_W  = RATE_W + 1;
  localparam int PROD_W = GAIN_W + MAG_W;
  localparam int PTR_W  = $clog2(LAG);
  localparam int FILL_W = $clog2(LAG + 1);
  localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(LAG - 1);
  localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(LAG);
  localparam logic signed [PROD_W-1:0] LIM_POS = PROD_W'(OFS_LIMIT);
  localparam logic signed [PROD_W-1:0] LIM_NEG = -LIM_POS;

  // circular history of accepted samples
  logic signed [ERR_W-1:0]  hist [LAG];
  logic [PTR_W-1:0]         wrPtr;
  logic [FILL_W-1:0]        fillCnt;
  logic                     histFull;
  logic signed [ERR_W-1:0]  oldest;
  logic signed [RATE_W-1:0] rate;

  assign histFull = (fillCnt == FULL_CNT);
  assign oldest   = hist[wrPtr];

  always_comb begin
    if (histFull)
      rate = RATE_W'(sampleErr) - RATE_W'(oldest);
    else
      rate = '0;
  end

  always_ff @(posedge clk) begin
    if (ctl.take) hist[wrPtr] <= sampleErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      fillCnt <= '0;
    end else if (ctl.clear) begin
      wrPtr   <= '0;
      fillCnt <= '0;
    end else if (ctl.take) begin
      wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (!histFull) fillCnt <= fillCnt + 1'b1;
    end
  end

  // peak capture over the window
  logic signed [RATE_W-1:0] posPeak, negPeak;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posPeak <= '0;
      negPeak <= '0;
    end else if (ctl.clear) begin
      posPeak <= '0;
      negPeak <= '0;
    end else if (ctl.take) begin
      if (rate > posPeak) posPeak <= rate;
      if (rate < negPeak) negPeak <= rate;
    end
  end

  // peak selection, gain and clamp
  logic signed [MAG_W-1:0]  posWide, negMag, chosen;
  logic                     posWins, threshOk;
  logic signed [GAIN_W-1:0] gainSigned;
  logic signed [PROD_W-1:0] product, scaled, clamped;

  always_comb begin
    posWide    = MAG_W'(posPeak);
    negMag     = -MAG_W'(negPeak);
    posWins    = posWide > negMag;
    threshOk   = $unsigned(posWide) >= MAG_W'(posThresh);
    if (posWins)
      chosen = threshOk ? posWide : '0;
    else
      chosen = MAG_W'(negPeak);
    gainSigned = {~gainCode[GAIN_W-1], gainCode[GAIN_W-2:0]};
    product    = PROD_W'(gainSigned) * PROD_W'(chosen);
    scaled     = product >>> GAIN_SHIFT;
    if (scaled > LIM_POS)
      clamped = LIM_POS;
    else if (scaled < LIM_NEG)
      clamped = LIM_NEG;
    else
      clamped = scaled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalOffset <= '0;
      offsetValid    <= 1'b0;
    end else if (ctl.clear) begin
      intervalOffset <= '0;
      offsetValid    <= 1'b0;
    end else begin
      offsetValid <= ctl.finish;
      if (ctl.finish) intervalOffset <= OFS_W'(clamped);
    end
  end

endmodule

// File: rtl/err_slope_corrector.sv
module err_slope_corrector
  import slope_corr_pkg::*;
#(
  parameter int ERR_W      = 12,
  parameter int LAG        = 112,
  parameter int WIN        = 225,
  parameter int GAIN_W     = 14,
  parameter int GAIN_SHIFT = 10,
  parameter int OFS_LIMIT  = 24,
  parameter int OFS_W      = $clog2(OFS_LIMIT + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    runStart,
  input  logic                    sampleValid,
  input  logic signed [ERR_W-1:0] sampleErr,
  input  logic [GAIN_W-1:0]       gainCode,
  input  logic [ERR_W-1:0]        posThresh,
  output logic signed [OFS_W-1:0] intervalOffset,
  output logic                    offsetValid
);

  ctlStrobes_t ctl;

  slope_corr_ctrl #(
    .WIN(WIN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runStart   (runStart),
    .sampleValid(sampleValid),
    .ctl        (ctl)
  );

  slope_corr_dp #(
    .ERR_W     (ERR_W),
    .LAG       (LAG),
    .GAIN_W    (GAIN_W),
    .GAIN_SHIFT(GAIN_SHIFT),
    .OFS_LIMIT (OFS_LIMIT),
    .OFS_W     (OFS_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .sampleErr     (sampleErr),
    .gainCode      (gainCode),
    .posThresh     (posThresh),
    .intervalOffset(intervalOffset),
    .offsetValid   (offsetValid)
  );

endmodule

// File: rtl/err_slope_corrector_chk.sv
module err_slope_corrector_chk #(
  parameter int OFS_LIMIT = 24,
  parameter int OFS_W     = 6
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    runStart,
  input logic signed [OFS_W-1:0] intervalOffset,
  input logic                    offsetValid
);

  localparam logic signed [OFS_W-1:0] LIM_P = OFS_W'(OFS_LIMIT);
  localparam logic signed [OFS_W-1:0] LIM_N = -LIM_P;

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    offsetValid |=> !offsetValid);

  a_r8_within_limit: assert property (@(posedge clk) disable iff (!rstN)
    (intervalOffset <= LIM_P) && (intervalOffset >= LIM_N));

  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    runStart |=> (intervalOffset == '0) && !offsetValid);

  a_r4_offset_held: assert property (@(posedge clk) disable iff (!rstN)
    !runStart |=> (offsetValid || $stable(intervalOffset)));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (intervalOffset == '0) && !offsetValid);

endmodule

bind err_slope_corrector err_slope_corrector_chk #(
  .OFS_LIMIT(OFS_LIMIT),
  .OFS_W    (OFS_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .runStart      (runStart),
  .intervalOffset(intervalOffset),
  .offsetValid   (offsetValid)
);

// File: tb/test_err_slope_corrector.sv
module test_err_slope_corrector;

  localparam int CLK_PERIOD = 12;
  localparam int ERR_W  = 12;
  localparam int LAG    = 112;
  localparam int WIN    = 225;
  localparam int GAIN_W = 14;
  localparam int OFS_W  = 6;
  localparam int G0     = 8192;
  localparam int NVEC   = 12;
  localparam int NEVER  = 1000;

  // base, slopeA, breakIdx, slopeB, gainCode, posThresh, expected offset
  localparam int VT [NVEC][7] = '{
    '{1500,  0, NEVER,   0, G0+20,    0,   0},
    '{   0,  8, NEVER,   0, G0+20,    0,  17},
    '{   0, -8, NEVER,   0, G0+20,    0, -18},
    '{   0,  8, NEVER,   0, G0+256,   0,  24},
    '{   0, -8, NEVER,   0, G0+256,   0, -24},
    '{   0,  8, NEVER,   0, G0,       0,   0},
    '{   0,  8, NEVER,   0, G0-20,    0, -18},
    '{   0,  3, NEVER,   0, G0+20,  400,   0},
    '{   0, -3, NEVER,   0, G0+20,  400,  -7},
    '{   0,  4,   150,  -6, G0+20,    0,   8},
    '{   0,  2,   130, -10, G0+20,    0, -18},
    '{   0,  3, NEVER,   0, G0+20,  336,   6}
  };
  localparam string VTAG [NVEC] = '{
    "R2 constant error", "R3 rising ramp", "R3 falling ramp",
    "R8 clamp high", "R8 clamp low", "R6 zero gain", "R6 negative gain",
    "R7 positive below threshold", "R7 negative ignores threshold",
    "R5 positive peak wins", "R5 negative peak wins", "R7 threshold reached"
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runStart = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [ERR_W-1:0] sampleErr = '0;
  logic [GAIN_W-1:0] gainCode = 14'h2000;
  logic [ERR_W-1:0] posThresh = '0;
  logic signed [OFS_W-1:0] intervalOffset;
  logic offsetValid;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  err_slope_corrector i_err_slope_corrector (
    .clk           (clk),
    .rstN          (rstN),
    .runStart      (runStart),
    .sampleValid   (sampleValid),
    .sampleErr     (sampleErr),
    .gainCode      (gainCode),
    .posThresh     (posThresh),
    .intervalOffset(intervalOffset),
    .offsetValid   (offsetValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int errAt(input int base, input int a, input int brk,
                               input int b, input int k);
    if (k < brk) return base + a * k;
    return base + a * brk + b * (k - brk);
  endfunction

  task automatic startRun(input int gain, input int th, input string tag);
    @(negedge clk);
    gainCode    = GAIN_W'(gain);
    posThresh   = ERR_W'(th);
    runStart    = 1'b1;
    sampleValid = 1'b0;
    @(negedge clk);
    runStart = 1'b0;
    // R10: cleared on the edge after the start pulse
    check(intervalOffset == 0 && !offsetValid, {tag, " R10 cleared at start"},
          int'(intervalOffset), 0);
  endtask

  task automatic feed(input int base, input int a, input int brk, input int b,
                      input int n, input bit gap);
    for (int k = 0; k < n; k++) begin
      sampleValid = 1'b1;
      sampleErr   = ERR_W'(errAt(base, a, brk, b, k));
      @(negedge clk);
      if (gap && k != n - 1) begin
        sampleValid = 1'b0;
        sampleErr   = 12'sd2000;
        @(negedge clk);
      end
    end
    sampleValid = 1'b0;
  endtask

  // called at the negedge after the edge that took the last sample
  task automatic finishCheck(input int exp, input string tag);
    check(!offsetValid, {tag, " R9 no strobe one edge after last sample"},
          int'(offsetValid), 0);
    @(negedge clk);
    check(offsetValid, {tag, " R9 strobe on second edge"}, int'(offsetValid), 1);
    check(int'(intervalOffset) == exp, tag, int'(intervalOffset), exp);
    @(negedge clk);
    check(!offsetValid, {tag, " R9 strobe lasts one cycle"}, int'(offsetValid), 0);
    check(int'(intervalOffset) == exp, {tag, " R4 held"}, int'(intervalOffset), exp);
  endtask

  task automatic runVec(input int base, input int a, input int brk, input int b,
                        input int gain, input int th, input bit gap,
                        input int exp, input string tag);
    startRun(gain, th, tag);
    feed(base, a, brk, b, WIN, gap);
    finishCheck(exp, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(intervalOffset == 0, "R1 reset offset", int'(intervalOffset), 0);
    check(!offsetValid, "R1 reset strobe", int'(offsetValid), 0);
    rstN = 1'b1;

    // R11: samples before any run start are ignored
    feed(0, 8, NEVER, 0, WIN + 5, 1'b0);
    repeat (3) @(negedge clk);
    check(intervalOffset == 0 && !offsetValid, "R11 ignored before first start",
          int'(intervalOffset), 0);

    for (int v = 0; v < NVEC; v++) begin
      runVec(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4], VT[v][5],
             1'b0, VT[v][6], VTAG[v]);
    end

    // R4: samples after the window change nothing
    runVec(0, 8, NEVER, 0, G0 + 20, 0, 1'b0, 17, "R4 base run");
    begin
      bit sawStrobe = 1'b0;
      bit moved = 1'b0;
      for (int k = 0; k < 60; k++) begin
        sampleValid = 1'b1;
        sampleErr   = ERR_W'(-30 * k);
        @(negedge clk);
        if (offsetValid) sawStrobe = 1'b1;
        if (intervalOffset != 17) moved = 1'b1;
      end
      sampleValid = 1'b0;
      check(!sawStrobe, "R4 no strobe after window", int'(sawStrobe), 0);
      check(!moved, "R4 offset held after window", int'(intervalOffset), 17);
    end

    // R11: gaps in the sample strobe do not advance the window
    runVec(0, -8, NEVER, 0, G0 + 20, 0, 1'b1, -18, "R11 gapped samples");

    // R10: restart mid-window discards a large captured peak
    startRun(G0 + 256, 0, "R10 first half");
    feed(0, 8, NEVER, 0, 200, 1'b0);
    runVec(0, -3, NEVER, 0, G0 + 20, 0, 1'b0, -7, "R10 restart mid-window");

    // R10: sample coinciding with the start pulse is not taken
    @(negedge clk);
    gainCode = GAIN_W'(G0 + 20);
    posThresh = '0;
    runStart = 1'b1;
    sampleValid = 1'b1;
    sampleErr = 12'sd2000;
    @(negedge clk);
    runStart = 1'b0;
    sampleValid = 1'b0;
    feed(0, 8, NEVER, 0, WIN, 1'b0);
    finishCheck(17, "R10 sample with start pulse dropped");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule